// File: doc/BRIEF.md
# Paged Host Target Address Decoder

This block sits behind a 32-bit host bus target engine and turns each accepted inbound access into a single local request. The device claims a 128 KB memory window. The upper address bits are only compared with a base value. The low 17 bits select one of four local regions:

- device registers;
- kernel RAM;
- an indirect port into internal program and data memory;
- a 64 KB window onto a large external memory.

For the external window, a host-programmed page register supplies the upper address bits. The block then issues a dword address with the two byte-offset bits removed.

Reads carry a prefetch count, so the engine knows how many dwords past the requested one it may fetch ahead. That count comes from a programmable limit. It is forced to zero for targets where an extra read would cause a side effect: the data FIFO window in register space, and the indirect port while that port auto-increments. A one-bit swap mode reverses byte order on both the write-data and read-data paths. The decoded request and the returned read data are registered and appear one clock after their inputs.

Top module: `tgt_addr_decoder`

## Requirements
- R1: After reset, no request or read response is issued. The page register reads 0x0000, the read-count limit reads 0xFF and the swap mode reads 0.
- R2: An access whose address bits 31:17 differ from `bar_base` produces no request.
- R3: An access flagged as I/O space produces no request, even when its address matches the base.
- R4: A matching access produces exactly one request, one cycle after it is presented. Its region code depends on the offset (address bits 16:0): 0 for offsets below 0x04000 (registers), 1 for 0x04000–0x07FFF (kernel RAM), 2 for 0x08000–0x0FFFF (indirect port) and 3 for 0x10000–0x1FFFF (external window). For codes 0–2, `req_loc_addr` carries the full 17-bit offset and `req_ext_addr` is 0.
- R5: For region 3, `req_ext_addr` is {page register, offset bits 15:2}, a 30-bit dword address, and `req_loc_addr` is 0. Offset bits 1:0 do not affect the request.
- R6: A page write loads the 16-bit page register. The new value is seen on `page_q` and is used by every later external access.
- R7: A read to an ordinary target carries `req_prefetch` equal to the read-count limit in force when the access was presented. A write always carries 0. The limit is 8 bits wide (0 to 255) and is loaded by a count write.
- R8: A read to the register-space FIFO window (byte offsets `FIFO_LO` to `FIFO_HI`, by default 0x00380 to 0x003FF) carries a prefetch of 0.
- R9: A read to the indirect port carries a prefetch of 0 while `ind_autoinc` is 1, and the programmed limit while it is 0.
- R10: While the swap mode is 1, the bytes of `req_wdata` are those of `acc_wdata` in reverse order, and the bytes of `host_rdata` are those of `rsp_rdata` in reverse order. While it is 0, both paths pass data unchanged. `host_rvalid` follows `rsp_valid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_base | input | 15 | Value compared with address bits 31:17 |
| acc_valid | input | 1 | Inbound access presented this cycle |
| acc_io | input | 1 | Access is in I/O space |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Inbound byte address |
| acc_wdata | input | 32 | Inbound write data |
| ind_autoinc | input | 1 | Indirect port is auto-incrementing |
| cfg_page_we | input | 1 | Load page register |
| cfg_page_wdata | input | 16 | New page value |
| cfg_cnt_we | input | 1 | Load read-count limit |
| cfg_cnt_wdata | input | 8 | New read-count limit |
| cfg_swap_we | input | 1 | Load swap mode |
| cfg_swap_wdata | input | 1 | New swap mode |
| rsp_valid | input | 1 | Local read data returned |
| rsp_rdata | input | 32 | Local read data |
| req_valid | output | 1 | Local request issued |
| req_write | output | 1 | Request is a write |
| req_region | output | 2 | Region code |
| req_loc_addr | output | 17 | Offset for regions 0–2 |
| req_ext_addr | output | 30 | External dword address for region 3 |
| req_wdata | output | 32 | Write data after optional swap |
| req_prefetch | output | 8 | Dwords that may be fetched ahead |
| host_rvalid | output | 1 | Read data ready for host |
| host_rdata | output | 32 | Read data after optional swap |
| page_q | output | 16 | Current page register |
| rdcnt_q | output | 8 | Current read-count limit |
| swap_q | output | 1 | Current swap mode |

## Verification
The assertions assume that `acc_valid` is never high in the same cycle as a configuration write. In that case the access would see the old settings while a check reading `rdcnt_q` one cycle later would see the new one. The bench therefore always applies configuration writes in their own cycles, before an access. The assertions also assume `bar_base` is held steady while an access is pending, and the stimulus changes it only between accesses.

// File: rtl/tgt_dec_pkg.sv
package tgt_dec_pkg;
  typedef enum logic [1:0] {
    RGN_REGS = 2'd0,
    RGN_KRAM = 2'd1,
    RGN_IND  = 2'd2,
    RGN_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/tgt_cfg_regs.sv
module tgt_cfg_regs #(
  parameter int PAGE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              swap_we,
  input  logic              swap_wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              swap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      cnt_q  <= '1;
      swap_q <= 1'b0;
    end else begin
      if (page_we) page_q <= page_wdata;
      if (cnt_we)  cnt_q  <= cnt_wdata;
      if (swap_we) swap_q <= swap_wdata;
    end
  end

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (page_q == '0 && cnt_q == '1 && !swap_q)); // R1
endmodule

// File: rtl/tgt_byte_swap.sv
module tgt_byte_swap #(
  parameter int DATA_W = 32
) (
  input  logic              swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = swap ? din[8*(NBYTES-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/tgt_region_decode.sv
module tgt_region_decode
  import tgt_dec_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 17,
  parameter int          PAGE_W   = 16,
  parameter int          CNT_W    = 8,
  parameter logic [16:0] FIFO_LO  = 17'h00380,
  parameter logic [16:0] FIFO_HI  = 17'h003FF,
  localparam int         BASE_W   = ADDR_W - WIN_BITS,
  localparam int         EXT_W    = PAGE_W + WIN_BITS - 3
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BASE_W-1:0]   bar_base,
  input  logic                valid,
  input  logic                io,
  input  logic                write,
  input  logic                ind_autoinc,
  input  logic [PAGE_W-1:0]   page,
  input  logic [CNT_W-1:0]    cnt_limit,
  output logic                hit,
  output region_e             region,
  output logic [WIN_BITS-1:0] loc_addr,
  output logic [EXT_W-1:0]    ext_addr,
  output logic [CNT_W-1:0]    prefetch
);
  logic [WIN_BITS-1:0] offs;
  logic                no_fetch_ahead;

  assign offs = addr[WIN_BITS-1:0];
  assign hit  = valid && !io && (addr[ADDR_W-1:WIN_BITS] == bar_base);

  always_comb begin
    if (offs[WIN_BITS-1])      region = RGN_EXT;
    else if (offs[WIN_BITS-2]) region = RGN_IND;
    else if (offs[WIN_BITS-3]) region = RGN_KRAM;
    else                       region = RGN_REGS;
  end

  always_comb begin
    loc_addr = '0;
    ext_addr = '0;
    if (region == RGN_EXT) ext_addr = {page, offs[WIN_BITS-2:2]};
    else                   loc_addr = offs;
  end

  always_comb begin
    no_fetch_ahead = 1'b0;
    if (region == RGN_REGS && offs >= FIFO_LO[WIN_BITS-1:0] && offs <= FIFO_HI[WIN_BITS-1:0])
      no_fetch_ahead = 1'b1;
    if (region == RGN_IND && ind_autoinc)
      no_fetch_ahead = 1'b1;
  end

  assign prefetch = (write || no_fetch_ahead) ? '0 : cnt_limit;
endmodule

// File: rtl/tgt_addr_decoder.sv
module tgt_addr_decoder
  import tgt_dec_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          WIN_BITS = 17,
  parameter int          PAGE_W   = 16,
  parameter int          CNT_W    = 8,
  parameter logic [16:0] FIFO_LO  = 17'h00380,
  parameter logic [16:0] FIFO_HI  = 17'h003FF,
  localparam int         BASE_W   = ADDR_W - WIN_BITS,
  localparam int         EXT_W    = PAGE_W + WIN_BITS - 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BASE_W-1:0]   bar_base,
  input  logic                acc_valid,
  input  logic                acc_io,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic                ind_autoinc,
  input  logic                cfg_page_we,
  input  logic [PAGE_W-1:0]   cfg_page_wdata,
  input  logic                cfg_cnt_we,
  input  logic [CNT_W-1:0]    cfg_cnt_wdata,
  input  logic                cfg_swap_we,
  input  logic                cfg_swap_wdata,
  input  logic                rsp_valid,
  input  logic [DATA_W-1:0]   rsp_rdata,
  output logic                req_valid,
  output logic                req_write,
  output logic [1:0]          req_region,
  output logic [WIN_BITS-1:0] req_loc_addr,
  output logic [EXT_W-1:0]    req_ext_addr,
  output logic [DATA_W-1:0]   req_wdata,
  output logic [CNT_W-1:0]    req_prefetch,
  output logic                host_rvalid,
  output logic [DATA_W-1:0]   host_rdata,
  output logic [PAGE_W-1:0]   page_q,
  output logic [CNT_W-1:0]    rdcnt_q,
  output logic                swap_q
);
  logic                hit;
  region_e             dec_region;
  logic [WIN_BITS-1:0] dec_loc;
  logic [EXT_W-1:0]    dec_ext;
  logic [CNT_W-1:0]    dec_pf;
  logic [DATA_W-1:0]   wdata_sw;
  logic [DATA_W-1:0]   rdata_sw;

  tgt_cfg_regs #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .page_we    (cfg_page_we),
    .page_wdata (cfg_page_wdata),
    .cnt_we     (cfg_cnt_we),
    .cnt_wdata  (cfg_cnt_wdata),
    .swap_we    (cfg_swap_we),
    .swap_wdata (cfg_swap_wdata),
    .page_q     (page_q),
    .cnt_q      (rdcnt_q),
    .swap_q     (swap_q)
  );

  tgt_region_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
    .FIFO_LO(FIFO_LO), .FIFO_HI(FIFO_HI)
  ) u_dec (
    .addr        (acc_addr),
    .bar_base    (bar_base),
    .valid       (acc_valid),
    .io          (acc_io),
    .write       (acc_write),
    .ind_autoinc (ind_autoinc),
    .page        (page_q),
    .cnt_limit   (rdcnt_q),
    .hit         (hit),
    .region      (dec_region),
    .loc_addr    (dec_loc),
    .ext_addr    (dec_ext),
    .prefetch    (dec_pf)
  );

  tgt_byte_swap #(.DATA_W(DATA_W)) u_wswap (
    .swap (swap_q), .din (acc_wdata), .dout (wdata_sw)
  );

  tgt_byte_swap #(.DATA_W(DATA_W)) u_rswap (
    .swap (swap_q), .din (rsp_rdata), .dout (rdata_sw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid    <= 1'b0;
      req_write    <= 1'b0;
      req_region   <= '0;
      req_loc_addr <= '0;
      req_ext_addr <= '0;
      req_wdata    <= '0;
      req_prefetch <= '0;
      host_rvalid  <= 1'b0;
      host_rdata   <= '0;
    end else begin
      req_valid   <= hit;
      host_rvalid <= rsp_valid;
      if (hit) begin
        req_write    <= acc_write;
        req_region   <= dec_region;
        req_loc_addr <= dec_loc;
        req_ext_addr <= dec_ext;
        req_wdata    <= wdata_sw;
        req_prefetch <= dec_pf;
      end
      if (rsp_valid) host_rdata <= rdata_sw;
    end
  end

  AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[ADDR_W-1:WIN_BITS] != bar_base) |=> !req_valid); // R2
  AST_IO_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_io) |=> !req_valid); // R3
  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_io && acc_addr[ADDR_W-1:WIN_BITS] == bar_base) |=> req_valid); // R4
  AST_WRITE_NO_PREFETCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> req_prefetch == '0); // R7
  AST_PREFETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_prefetch <= $past(rdcnt_q)); // R7
  AST_EXT_ONLY_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_region != 2'd3) |-> req_ext_addr == '0); // R5
endmodule

// File: tb/tgt_addr_decoder_tb.sv
module tgt_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] bar_base = 15'h2A55;
  logic        acc_valid = 0, acc_io = 0, acc_write = 0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        ind_autoinc = 0;
  logic        cfg_page_we = 0, cfg_cnt_we = 0, cfg_swap_we = 0, cfg_swap_wdata = 0;
  logic [15:0] cfg_page_wdata = '0;
  logic [7:0]  cfg_cnt_wdata = '0;
  logic        rsp_valid = 0;
  logic [31:0] rsp_rdata = '0;
  logic        req_valid, req_write, host_rvalid, swap_q;
  logic [1:0]  req_region;
  logic [16:0] req_loc_addr;
  logic [29:0] req_ext_addr;
  logic [31:0] req_wdata, host_rdata;
  logic [7:0]  req_prefetch, rdcnt_q;
  logic [15:0] page_q;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tgt_addr_decoder dut_i (
    .clk(clk), .rst(rst), .bar_base(bar_base), .acc_valid(acc_valid), .acc_io(acc_io),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ind_autoinc(ind_autoinc), .cfg_page_we(cfg_page_we), .cfg_page_wdata(cfg_page_wdata),
    .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_wdata(cfg_cnt_wdata), .cfg_swap_we(cfg_swap_we),
    .cfg_swap_wdata(cfg_swap_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
    .req_loc_addr(req_loc_addr), .req_ext_addr(req_ext_addr), .req_wdata(req_wdata),
    .req_prefetch(req_prefetch), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .page_q(page_q), .rdcnt_q(rdcnt_q), .swap_q(swap_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // Present one access for one cycle; outputs are sampled at the following negedge.
  task automatic access(input logic wr, input logic io, input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_io = io; acc_addr = a; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0; acc_io = 0;
  endtask

  task automatic cfg_page(input logic [15:0] v);
    @(negedge clk); cfg_page_we = 1; cfg_page_wdata = v;
    @(negedge clk); cfg_page_we = 0;
  endtask

  task automatic cfg_cnt(input logic [7:0] v);
    @(negedge clk); cfg_cnt_we = 1; cfg_cnt_wdata = v;
    @(negedge clk); cfg_cnt_we = 0;
  endtask

  task automatic cfg_swap(input logic v);
    @(negedge clk); cfg_swap_we = 1; cfg_swap_wdata = v;
    @(negedge clk); cfg_swap_we = 0;
  endtask

  function automatic logic [31:0] hit_addr(input logic [16:0] off);
    return {bar_base, off};
  endfunction

  task automatic t_reset;
    check("R1 req_valid", {31'd0, req_valid}, 32'd0);
    check("R1 host_rvalid", {31'd0, host_rvalid}, 32'd0);
    check("R1 page", {16'd0, page_q}, 32'h0000);
    check("R1 rdcnt", {24'd0, rdcnt_q}, 32'hFF);
    check("R1 swap", {31'd0, swap_q}, 32'd0);
  endtask

  task automatic t_miss_and_io;
    access(0, 0, {15'h2A54, 17'h00100}, '0);
    check("R2 base mismatch", {31'd0, req_valid}, 32'd0);
    access(0, 1, hit_addr(17'h00100), '0);
    check("R3 io space", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_regions;
    logic [16:0] offs [4] = '{17'h00010, 17'h05004, 17'h0ABC8, 17'h1FFFC};
    for (int i = 0; i < 3; i++) begin
      access(1, 0, hit_addr(offs[i]), 32'h1);
      check("R4 valid", {31'd0, req_valid}, 32'd1);
      check("R4 region", {30'd0, req_region}, i);
      check("R4 loc_addr", {15'd0, req_loc_addr}, {15'd0, offs[i]});
      check("R4 ext zero", {2'd0, req_ext_addr}, 32'd0);
    end
    access(0, 0, hit_addr(17'h07FFC), '0);
    check("R4 kram top", {30'd0, req_region}, 32'd1);
    access(0, 0, hit_addr(17'h08000), '0);
    check("R4 ind bottom", {30'd0, req_region}, 32'd2);
    @(negedge clk);
    check("R4 single request", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_ext_page;
    cfg_page(16'h1234);
    check("R6 page visible", {16'd0, page_q}, 32'h1234);
    access(0, 0, hit_addr(17'h1ABCF), '0);
    check("R5 region", {30'd0, req_region}, 32'd3);
    check("R5 ext addr", {2'd0, req_ext_addr}, {2'd0, 16'h1234, 14'h2AF3});
    check("R5 loc zero", {15'd0, req_loc_addr}, 32'd0);
    access(0, 0, hit_addr(17'h1ABCC), '0);
    check("R5 low bits ignored", {2'd0, req_ext_addr}, {2'd0, 16'h1234, 14'h2AF3});
    cfg_page(16'hFFFF);
    access(1, 0, hit_addr(17'h10000), 32'h5);
    check("R6 new page used", {2'd0, req_ext_addr}, {2'd0, 16'hFFFF, 14'h0000});
  endtask

  task automatic t_prefetch;
    access(0, 0, hit_addr(17'h04010), '0);
    check("R7 default limit", {24'd0, req_prefetch}, 32'hFF);
    cfg_cnt(8'd7);
    check("R7 limit visible", {24'd0, rdcnt_q}, 32'd7);
    access(0, 0, hit_addr(17'h1F000), '0);
    check("R7 ext read", {24'd0, req_prefetch}, 32'd7);
    access(1, 0, hit_addr(17'h1F000), 32'h9);
    check("R7 write zero", {24'd0, req_prefetch}, 32'd0);
    access(0, 0, hit_addr(17'h00380), '0);
    check("R8 fifo low", {24'd0, req_prefetch}, 32'd0);
    access(0, 0, hit_addr(17'h003FC), '0);
    check("R8 fifo high", {24'd0, req_prefetch}, 32'd0);
    access(0, 0, hit_addr(17'h00400), '0);
    check("R8 above fifo", {24'd0, req_prefetch}, 32'd7);
    access(0, 0, hit_addr(17'h0037C), '0);
    check("R8 below fifo", {24'd0, req_prefetch}, 32'd7);
    ind_autoinc = 1;
    access(0, 0, hit_addr(17'h0C000), '0);
    check("R9 autoinc", {24'd0, req_prefetch}, 32'd0);
    ind_autoinc = 0;
    access(0, 0, hit_addr(17'h0C000), '0);
    check("R9 direct", {24'd0, req_prefetch}, 32'd7);
    cfg_cnt(8'd0);
    access(0, 0, hit_addr(17'h1F000), '0);
    check("R7 zero limit", {24'd0, req_prefetch}, 32'd0);
  endtask

  task automatic t_swap;
    access(1, 0, hit_addr(17'h00020), 32'hA1B2C3D4);
    check("R10 write pass", req_wdata, 32'hA1B2C3D4);
    @(negedge clk); rsp_valid = 1; rsp_rdata = 32'h11223344;
    @(negedge clk); rsp_valid = 0;
    check("R10 rvalid", {31'd0, host_rvalid}, 32'd1);
    check("R10 read pass", host_rdata, 32'h11223344);
    cfg_swap(1);
    check("R10 swap visible", {31'd0, swap_q}, 32'd1);
    access(1, 0, hit_addr(17'h00020), 32'hA1B2C3D4);
    check("R10 write swapped", req_wdata, rev(32'hA1B2C3D4));
    @(negedge clk); rsp_valid = 1; rsp_rdata = 32'h11223344;
    @(negedge clk); rsp_valid = 0;
    check("R10 read swapped", host_rdata, rev(32'h11223344));
    @(negedge clk);
    check("R10 rvalid drops", {31'd0, host_rvalid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_miss_and_io();
    t_regions();
    t_ext_page();
    t_prefetch();
    t_swap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule